// File: doc/BRIEF.md
# Link health monitor with receiver recovery

This block answers a single question on request: is the serial link up? It also clears one known stuck condition while doing so. A check starts with a one-cycle pulse on `check_req_i`. The block then samples two debug status words from the link controller. If the link reports up and has finished training, the answer is up at once. If the link reports up but is still training, the block pauses for a programmable number of cycles and looks again. It does this a bounded number of times before it gives up.

On the not-up path, the block reads a receive-status register in the PHY through an external register-access engine. It also inspects the controller's state field. If the controller is parked in the receiver-lock recovery state and the PHY receive-valid bit is low, the speed change is stuck. The block then forces the PHY receiver off and on again. It reads an override register, sets two override bits and writes it back. It waits a programmable hold time, then reads the register again, clears the same two bits and writes it back. Every recovery ends with a not-up result, so the caller checks again later.

All delays are cycle counts given by parameters. The access engine uses a request/done handshake and reports errors with `acc_err_i`.

Top module: `lhm_link_monitor`

## Requirements
- R1: While `rst_ni` is low and after its release, `result_valid_o`, `link_up_o`, `recov_busy_o` and `acc_req_o` are 0.
- R2: `dbg1_i` bit 4 high means link up, and bit 29 high means training in progress. A check that finds bit 4 = 1 and bit 29 = 0 at its first sample yields `link_up_o` = 1 with a one-cycle `result_valid_o`. The first sample happens the cycle after the request is taken, and the result shows one cycle later. `result_valid_o` is always a single-cycle pulse.
- R3: If the link is up but training, the block pauses `RETRY_WAIT` cycles and samples again, with up to `RETRIES` re-samples. The first sample that shows up and not training gives an up result. Each re-sample adds `RETRY_WAIT`+1 cycles of latency.
- R4: If the link is still training after the last re-sample, the block takes the not-up path. If bit 4 is low at any sample, it takes the not-up path at once. The not-up path reads PHY address 0x100D and never reports up.
- R5: On the not-up path, if bit 0 (receive valid) of the 0x100D read data is 1, the result is not up and no PHY write is issued.
- R6: Recovery runs only when receive valid is 0 and `dbg0_i[5:0]` equals 0x0D. Any other state field gives a not-up result with no PHY write.
- R7: Recovery reads PHY address 0x1005 and writes back the read value with bits 5 and 3 set. It waits `HOLD_CYC` cycles after that write completes, then reads 0x1005 again and writes back the value with bits 5 and 3 cleared. All other bits pass through. The result is not up.
- R8: `recov_busy_o` is high from the first 0x1005 read request until the final write completes. It is low during the 0x100D read. When it falls, a not-up result is presented in the same cycle.
- R9: A check request that arrives while a check is running is ignored, and it does not cause a second result or further PHY accesses.
- R10: An access completing with `acc_err_i` = 1 ends the check at once with a not-up result, and no further access is issued.
- R11: `acc_req_o` stays high, with address, write flag and write data stable, until `acc_done_i`. Only recovery issues writes, and only to 0x1005.
- R12: `link_up_o` changes only together with `result_valid_o`. Between checks it holds the last result whatever `dbg1_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| check_req_i | input | 1 | Start a link check (ignored while busy) |
| dbg0_i | input | 32 | Debug word 0; bits 5:0 carry the controller state |
| dbg1_i | input | 32 | Debug word 1; bit 4 link up, bit 29 training |
| acc_req_o | output | 1 | PHY register access request, held until done |
| acc_we_o | output | 1 | Access is a write |
| acc_addr_o | output | 16 | PHY register address |
| acc_wdata_o | output | 16 | PHY write data |
| acc_rdata_i | input | 16 | PHY read data, valid with done |
| acc_done_i | input | 1 | Access completed (one cycle) |
| acc_err_i | input | 1 | Access timed out, valid with done |
| result_valid_o | output | 1 | One-cycle pulse: check finished |
| link_up_o | output | 1 | Result of the last check |
| recov_busy_o | output | 1 | Receiver recovery in progress |

## Verification
The main path is driven from a table of link conditions:
- A link that is up at once tells the fast path apart from the retry path.
- A training bit that clears at different times measures the retry cadence. The case that clears in time for the last re-sample and the case that misses it by one cycle pin down the retry limit.
- Not-up cases vary receive valid and the state field separately, so recovery can be seen to need both conditions. A case that is up but stuck training and also needs recovery shows that both paths chain.

Recovery is judged by the write data, the hold spacing between the set write and the clear read, and the exact width of the busy window. Directed cases cover a request made during recovery, an access error in mid-recovery, and a result held while the debug word changes.

// File: rtl/lhm_pkg.sv
package lhm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_RWAIT,
    ST_RD_RX,
    ST_RD_OV1,
    ST_WR_OV1,
    ST_HOLD,
    ST_RD_OV2,
    ST_WR_OV2
  } lhm_state_e;
endpackage

// File: rtl/lhm_timer.sv
module lhm_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/lhm_ovrd_patch.sv
module lhm_ovrd_patch #(
  parameter int unsigned       DW   = 16,
  parameter logic [DW-1:0]     MASK = '0
) (
  input  logic [DW-1:0] word_i,
  input  logic          set_i,
  output logic [DW-1:0] word_o
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (MASK[b]) begin : g_force
      assign word_o[b] = set_i;
    end else begin : g_pass
      assign word_o[b] = word_i[b];
    end
  end
endmodule

// File: rtl/lhm_link_monitor.sv
module lhm_link_monitor
  import lhm_pkg::*;
#(
  parameter int unsigned        DBG_W        = 32,
  parameter int unsigned        PHY_AW       = 16,
  parameter int unsigned        PHY_DW       = 16,
  parameter int unsigned        UP_BIT       = 4,
  parameter int unsigned        TRAIN_BIT    = 29,
  parameter int unsigned        STATE_W      = 6,
  parameter logic [STATE_W-1:0] RCVR_LOCK    = 6'h0D,
  parameter logic [PHY_AW-1:0]  RX_STAT_ADDR = 16'h100D,
  parameter logic [PHY_AW-1:0]  OVRD_ADDR    = 16'h1005,
  parameter logic [PHY_DW-1:0]  OVRD_MASK    = 16'h0028,
  parameter int unsigned        RX_VALID_BIT = 0,
  parameter int unsigned        RETRIES      = 5,
  parameter int unsigned        RETRY_WAIT   = 250000,
  parameter int unsigned        HOLD_CYC     = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              check_req_i,
  input  logic [DBG_W-1:0]  dbg0_i,
  input  logic [DBG_W-1:0]  dbg1_i,
  output logic              acc_req_o,
  output logic              acc_we_o,
  output logic [PHY_AW-1:0] acc_addr_o,
  output logic [PHY_DW-1:0] acc_wdata_o,
  input  logic [PHY_DW-1:0] acc_rdata_i,
  input  logic              acc_done_i,
  input  logic              acc_err_i,
  output logic              result_valid_o,
  output logic              link_up_o,
  output logic              recov_busy_o
);
  localparam int unsigned TMR_MAX = (RETRY_WAIT > HOLD_CYC) ? RETRY_WAIT : HOLD_CYC;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned RTY_W   = $clog2(RETRIES + 1);
  localparam logic [TMR_W-1:0] RWAIT_LD = TMR_W'(RETRY_WAIT - 1);
  localparam logic [TMR_W-1:0] HOLD_LD  = TMR_W'(HOLD_CYC - 1);
  localparam logic [RTY_W-1:0] RTY_LIM  = RTY_W'(RETRIES);

  lhm_state_e        state_q, state_d;
  logic [RTY_W-1:0]  rty_q, rty_d;
  logic [PHY_DW-1:0] ovrd_q, ovrd_d;
  logic              res_vld_q, res_vld_d;
  logic              up_q, up_d;
  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic              lnk_up, lnk_train, rx_valid, stuck_state;
  logic [PHY_DW-1:0] ovrd_set, ovrd_clr;

  assign lnk_up      = dbg1_i[UP_BIT];
  assign lnk_train   = dbg1_i[TRAIN_BIT];
  assign rx_valid    = acc_rdata_i[RX_VALID_BIT];
  assign stuck_state = (dbg0_i[STATE_W-1:0] == RCVR_LOCK);

  lhm_timer #(.W(TMR_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expired_o(tmr_exp)
  );

  lhm_ovrd_patch #(.DW(PHY_DW), .MASK(OVRD_MASK)) u_set (
    .word_i(ovrd_q), .set_i(1'b1), .word_o(ovrd_set)
  );

  lhm_ovrd_patch #(.DW(PHY_DW), .MASK(OVRD_MASK)) u_clr (
    .word_i(ovrd_q), .set_i(1'b0), .word_o(ovrd_clr)
  );

  always_comb begin
    state_d   = state_q;
    rty_d     = rty_q;
    ovrd_d    = ovrd_q;
    res_vld_d = 1'b0;
    up_d      = up_q;
    tmr_load  = 1'b0;
    tmr_val   = RWAIT_LD;
    unique case (state_q)
      ST_IDLE: if (check_req_i) begin
        state_d = ST_SAMPLE;
        rty_d   = '0;
      end
      ST_SAMPLE: begin
        if (lnk_up && !lnk_train) begin
          state_d = ST_IDLE; res_vld_d = 1'b1; up_d = 1'b1;
        end else if (lnk_up && rty_q != RTY_LIM) begin
          rty_d    = rty_q + 1'b1;
          state_d  = ST_RWAIT;
          tmr_load = 1'b1;
        end else begin
          state_d = ST_RD_RX;
        end
      end
      ST_RWAIT: if (tmr_exp) state_d = ST_SAMPLE;
      ST_RD_RX: if (acc_done_i) begin
        if (acc_err_i || rx_valid || !stuck_state) begin
          state_d = ST_IDLE; res_vld_d = 1'b1; up_d = 1'b0;
        end else begin
          state_d = ST_RD_OV1;
        end
      end
      ST_RD_OV1, ST_RD_OV2: if (acc_done_i) begin
        if (acc_err_i) begin
          state_d = ST_IDLE; res_vld_d = 1'b1; up_d = 1'b0;
        end else begin
          ovrd_d  = acc_rdata_i;
          state_d = (state_q == ST_RD_OV1) ? ST_WR_OV1 : ST_WR_OV2;
        end
      end
      ST_WR_OV1: if (acc_done_i) begin
        if (acc_err_i) begin
          state_d = ST_IDLE; res_vld_d = 1'b1; up_d = 1'b0;
        end else begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LD;
        end
      end
      ST_HOLD: if (tmr_exp) state_d = ST_RD_OV2;
      ST_WR_OV2: if (acc_done_i) begin
        state_d = ST_IDLE; res_vld_d = 1'b1; up_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rty_q     <= '0;
      ovrd_q    <= '0;
      res_vld_q <= 1'b0;
      up_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      rty_q     <= rty_d;
      ovrd_q    <= ovrd_d;
      res_vld_q <= res_vld_d;
      up_q      <= up_d;
    end
  end

  assign acc_req_o    = state_q inside {ST_RD_RX, ST_RD_OV1, ST_WR_OV1, ST_RD_OV2, ST_WR_OV2};
  assign acc_we_o     = state_q inside {ST_WR_OV1, ST_WR_OV2};
  assign acc_addr_o   = (state_q == ST_RD_RX) ? RX_STAT_ADDR : OVRD_ADDR;
  assign acc_wdata_o  = (state_q == ST_WR_OV1) ? ovrd_set : ovrd_clr;
  assign recov_busy_o = state_q inside {ST_RD_OV1, ST_WR_OV1, ST_HOLD, ST_RD_OV2, ST_WR_OV2};
  assign result_valid_o = res_vld_q;
  assign link_up_o      = up_q;
endmodule

// File: rtl/lhm_link_monitor_chk.sv
module lhm_link_monitor_chk #(
  parameter logic [15:0] OVRD_ADDR = 16'h1005
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        acc_req_o,
  input logic        acc_we_o,
  input logic [15:0] acc_addr_o,
  input logic [15:0] acc_wdata_o,
  input logic        acc_done_i,
  input logic        result_valid_o,
  input logic        link_up_o,
  input logic        recov_busy_o
);
  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o && !acc_done_i |=> acc_req_o && $stable(acc_addr_o) && $stable(acc_we_o)
                                 && $stable(acc_wdata_o));

  assert_write_scope_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o && acc_we_o |-> recov_busy_o && acc_addr_o == OVRD_ADDR);

  assert_result_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  assert_busy_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(recov_busy_o) |-> result_valid_o && !link_up_o);

  assert_quiet_after_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> !acc_req_o && !recov_busy_o);

  assert_up_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(link_up_o) |-> result_valid_o);
endmodule

bind lhm_link_monitor lhm_link_monitor_chk #(.OVRD_ADDR(OVRD_ADDR)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .acc_req_o     (acc_req_o),
  .acc_we_o      (acc_we_o),
  .acc_addr_o    (acc_addr_o),
  .acc_wdata_o   (acc_wdata_o),
  .acc_done_i    (acc_done_i),
  .result_valid_o(result_valid_o),
  .link_up_o     (link_up_o),
  .recov_busy_o  (recov_busy_o)
);

// File: tb/lhm_link_monitor_test.sv
`timescale 1ns/1ps
module lhm_link_monitor_test;
  localparam int RTRY = 5;
  localparam int RW   = 4;
  localparam int HOLD = 20;
  localparam int LAT  = 2;
  localparam logic [15:0] OVRD_INIT = 16'h8451;

  typedef struct packed {
    logic       up;
    logic [7:0] tl;
    logic       rxv;
    logic [5:0] st;
    logic       exp_up;
    logic       exp_rec;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd0,   1'b0, 6'h0D, 1'b1, 1'b0},
    '{1'b1, 8'd3,   1'b1, 6'h00, 1'b1, 1'b0},
    '{1'b1, 8'd26,  1'b1, 6'h00, 1'b1, 1'b0},
    '{1'b1, 8'd27,  1'b1, 6'h0D, 1'b0, 1'b0},
    '{1'b0, 8'd0,   1'b1, 6'h0D, 1'b0, 1'b0},
    '{1'b0, 8'd0,   1'b0, 6'h11, 1'b0, 1'b0},
    '{1'b0, 8'd0,   1'b0, 6'h0D, 1'b0, 1'b1},
    '{1'b1, 8'd200, 1'b0, 6'h0D, 1'b0, 1'b1},
    '{1'b0, 8'd0,   1'b0, 6'h0C, 1'b0, 1'b0}
  };

  logic        clk, rst_n, check_req;
  logic [31:0] dbg0, dbg1;
  logic        acc_req, acc_we, acc_done, acc_err;
  logic [15:0] acc_addr, acc_wdata, acc_rdata;
  logic        res_vld, link_up, busy;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, n_ops = 0, err_at = -1, rcnt = 0;
  logic        rxv_bit = 1'b0;
  logic [15:0] ovrd_mem = OVRD_INIT;
  int          log_cyc  [256];
  logic [15:0] log_addr [256];
  logic        log_we   [256];
  logic [15:0] log_dat  [256];

  lhm_link_monitor #(.RETRIES(RTRY), .RETRY_WAIT(RW), .HOLD_CYC(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .check_req_i(check_req),
    .dbg0_i(dbg0), .dbg1_i(dbg1),
    .acc_req_o(acc_req), .acc_we_o(acc_we), .acc_addr_o(acc_addr),
    .acc_wdata_o(acc_wdata), .acc_rdata_i(acc_rdata), .acc_done_i(acc_done),
    .acc_err_i(acc_err), .result_valid_o(res_vld), .link_up_o(link_up),
    .recov_busy_o(busy)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // PHY access engine model
  initial begin
    logic [15:0] rd;
    acc_done = 1'b0; acc_err = 1'b0; acc_rdata = '0;
    forever begin
      @(posedge clk);
      cyc++;
      if (acc_done) begin
        acc_done <= 1'b0; acc_err <= 1'b0;
      end else if (acc_req) begin
        if (rcnt == LAT) begin
          rcnt <= 0;
          acc_done <= 1'b1;
          acc_err  <= (n_ops == err_at);
          log_cyc[n_ops]  = cyc;
          log_addr[n_ops] = acc_addr;
          log_we[n_ops]   = acc_we;
          if (acc_we) begin
            log_dat[n_ops] = acc_wdata;
            if (acc_addr == 16'h1005 && n_ops != err_at) ovrd_mem = acc_wdata;
          end else begin
            rd = (acc_addr == 16'h1005) ? ovrd_mem : (16'hB460 | {15'h0, rxv_bit});
            acc_rdata <= rd;
            log_dat[n_ops] = rd;
          end
          n_ops++;
        end else rcnt <= rcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // caller sits at a negedge; request is raised there (n = 0)
  task automatic do_check(input logic up_b, input int tl, input logic rxv_b,
                          input logic [5:0] st, input int poke_at,
                          output int lat, output logic res_up, output int busy_n,
                          output int base);
    lat = -1; res_up = 1'b0; busy_n = 0; base = n_ops;
    rxv_bit = rxv_b;
    dbg0 = {26'h2A5A5A5, st};
    dbg1 = 32'h5A00A2E0;
    dbg1[4]  = up_b;
    dbg1[29] = (tl > 0);
    check_req = 1'b1;
    for (int n = 1; n < 3000; n++) begin
      @(negedge clk);
      if (n == 1) check_req = 1'b0;
      if (n == tl) dbg1[29] = 1'b0;
      if (poke_at > 0 && n == poke_at) check_req = 1'b1;
      if (poke_at > 0 && n == poke_at + 1) check_req = 1'b0;
      if (busy) busy_n++;
      if (res_vld) begin
        lat = n; res_up = link_up;
        break;
      end
    end
    check_req = 1'b0;
  endtask

  function automatic int count_ops(input int base, input logic [15:0] addr, input logic we);
    int c = 0;
    for (int i = base; i < n_ops; i++)
      if (log_addr[i] == addr && log_we[i] == we) c++;
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int lat, busy_n, base, exp_lat, j;
    logic res_up;
    string tag;
    check_req = 1'b0; dbg0 = '0; dbg1 = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!res_vld && !link_up && !busy && !acc_req, "R1 in reset", {res_vld, link_up, busy, acc_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!res_vld && !link_up && !busy && !acc_req, "R1 after reset", {res_vld, link_up, busy, acc_req}, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      do_check(t.up, int'(t.tl), t.rxv, t.st, 0, lat, res_up, busy_n, base);
      tag = t.exp_up ? ((t.tl == 0) ? "R2" : "R3") : (t.up ? "R4" : (t.exp_rec ? "R7" : (t.rxv ? "R5" : "R6")));
      chk(lat > 0 && res_up == t.exp_up, $sformatf("%s vec%0d result", tag, v), res_up, t.exp_up);
      if (t.exp_up) begin
        j = 0;
        while (1 + j * (RW + 1) < int'(t.tl)) j++;
        exp_lat = 2 + j * (RW + 1);
        chk(lat == exp_lat, $sformatf("%s vec%0d latency", tag, v), lat, exp_lat);
        chk(n_ops == base, $sformatf("%s vec%0d no access", tag, v), n_ops - base, 0);
      end else begin
        chk(count_ops(base, 16'h100D, 1'b0) == 1, $sformatf("R4 vec%0d status read", v),
            count_ops(base, 16'h100D, 1'b0), 1);
      end
      chk(count_ops(base, 16'h1005, 1'b1) == (t.exp_rec ? 2 : 0),
          $sformatf("%s vec%0d writes", t.exp_rec ? "R7" : (t.rxv ? "R5" : "R6"), v),
          count_ops(base, 16'h1005, 1'b1), t.exp_rec ? 2 : 0);
      if (t.exp_rec && n_ops - base == 5) begin
        chk(log_dat[base+2] == (OVRD_INIT | 16'h0028), $sformatf("R7 vec%0d set write", v),
            log_dat[base+2], OVRD_INIT | 16'h0028);
        chk(log_dat[base+4] == (log_dat[base+3] & ~16'h0028), $sformatf("R7 vec%0d clear write", v),
            log_dat[base+4], log_dat[base+3] & ~16'h0028);
        chk(log_cyc[base+3] - log_cyc[base+2] == HOLD + LAT + 2, $sformatf("R7 vec%0d hold spacing", v),
            log_cyc[base+3] - log_cyc[base+2], HOLD + LAT + 2);
        chk(busy_n == 4 * (LAT + 2) + HOLD, $sformatf("R8 vec%0d busy window", v),
            busy_n, 4 * (LAT + 2) + HOLD);
      end else begin
        chk(busy_n == 0, $sformatf("R8 vec%0d no busy", v), busy_n, 0);
      end
      repeat (3) @(negedge clk);
    end

    // R9: request while recovering is ignored
    do_check(1'b0, 0, 1'b0, 6'h0D, 15, lat, res_up, busy_n, base);
    chk(lat > 0 && !res_up, "R9 recovery result", res_up, 0);
    j = n_ops;
    begin
      int extra = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (res_vld || acc_req) extra++;
      end
      chk(extra == 0, "R9 no second check", extra, 0);
    end
    chk(n_ops == j, "R9 no extra access", n_ops - j, 0);

    // R10: error on the first override read aborts recovery
    err_at = n_ops + 1;
    do_check(1'b0, 0, 1'b0, 6'h0D, 0, lat, res_up, busy_n, base);
    err_at = -1;
    chk(lat > 0 && !res_up, "R10 abort result", res_up, 0);
    chk(n_ops - base == 2, "R10 access count", n_ops - base, 2);
    chk(busy_n == LAT + 2, "R10 busy window", busy_n, LAT + 2);
    repeat (10) @(negedge clk);
    chk(!acc_req && !busy, "R10 idle after abort", {acc_req, busy}, 0);

    // R12: held result
    do_check(1'b1, 0, 1'b1, 6'h00, 0, lat, res_up, busy_n, base);
    chk(res_up == 1'b1, "R12 up result", res_up, 1);
    dbg1[4] = 1'b0;
    repeat (10) @(negedge clk);
    chk(link_up == 1'b1 && !res_vld, "R12 holds", link_up, 1);
    do_check(1'b0, 0, 1'b1, 6'h00, 0, lat, res_up, busy_n, base);
    chk(lat > 0 && link_up == 1'b0, "R12 updates on result", link_up, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule